// File: doc/BRIEF.md
# Register-Write Command Stream Decoder

This block sits behind a fetch engine that streams 32-bit command words out of a memory buffer. It parses those words into register writes on a simple address/data port, and it attaches to every write the set of downstream hardware units currently targeted. Each command opens with a two-word header. The first header word holds an opcode and a 20-bit word-aligned relative offset, or else the fixed unit-select constant. The second header word holds a data value, a payload length, or a wrap/increment descriptor. Block commands are followed by their payload words.

Four write forms are parsed. A single write carries one value. An auto-increment block steps the address by 4 for each word. An indexed block sends every word to one address. A lookup-table block either holds its address or steps it by 4 and returns to the start offset after a programmable number of words. Each list must open with a unit-select command, and a unit select must be followed by a write command. A list that holds only a zero-mask select is an end-of-list marker. Any ordering violation, illegal mask, unknown opcode, misaligned offset or out-of-range wrap raises a sticky error. After that, the rest of the stream is swallowed until the `restart` pin is pulsed.

Both data interfaces use valid/ready. A word transfers on a rising edge where `in_valid` and `in_ready` are both high. A write transfers where `wr_valid` and `wr_ready` are both high. `wr_valid` may not drop, and the write fields may not change, while the write waits for `wr_ready`. `in_ready` is low whenever the single output slot is full and `wr_ready` is low. A stalled sink therefore stalls the command stream.

Top module: `regcmd_decoder`

## Requirements
- R1: After reset or a one-cycle `restart` pulse, `err` is 0, `wr_valid` is 0, `list_done` is 0 and `in_ready` is 1.
- R2: After reset, restart or an end-of-list marker, a first header word that is not the select constant 32'h180AC060 raises `err`.
- R3: A select command followed directly by another select command raises `err`.
- R4: The select mask is word 1 with all bits other than 4:0 (video units) and 21:17 (post-processing units) cleared, and it appears on `wr_sel` with each later write. A mask that is zero outside list start, or that has bits in both groups, raises `err`.
- R5: A header word 0 whose bits 30:27 are 4'b0010 is a single write. Word 1 is written once, to the address in word-0 bits 19:0.
- R6: Opcode 4'b1000 is an auto-increment block. Word-1 bits 13:0 give the count N. The next N words are written to offset + 4*k, modulo 2^20. N = 0 means there is no payload.
- R7: Opcode 4'b0110 is an indexed block. The next N words are all written to the offset.
- R8: Opcode 4'b1010 is a lookup-table block. Word-1 bits 13:0 give N and bits 19:16 give the wrap W. If word-1 bit 31 is clear, word k goes to offset + 4*(k mod W). If bit 31 is set, every word goes to the offset.
- R9: In a lookup-table block, a wrap W below 2 raises `err`.
- R10: A header word 0 that is neither the select constant nor one of the four opcodes, or whose bits 1:0 are not zero, raises `err`.
- R11: `err` stays high until restart. While `err` is high, `in_ready` is 1, every input word is discarded, and no new write is issued.
- R12: A zero-mask select at list start pulses `list_done` for one cycle, in the cycle after its second word is accepted, without raising `err`. The parser then again expects a select.
- R13: A write is presented on `wr_valid` in the cycle after its data word is accepted. It is held with stable fields until `wr_ready`, and `in_ready` is 0 while it is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Synchronous start of a new list; clears the error |
| in_valid | input | 1 | Command word valid |
| in_ready | output | 1 | Command word accepted when valid is also high |
| in_data | input | 32 | Command word |
| wr_valid | output | 1 | Register write pending |
| wr_ready | input | 1 | Sink takes the pending write |
| wr_addr | output | 20 | Relative register address |
| wr_data | output | 32 | Write data |
| wr_sel | output | 22 | Unit-select mask in force for this write |
| err | output | 1 | Sticky malformed-stream flag |
| list_done | output | 1 | One-cycle end-of-list pulse |

## Verification
Three results have fixed timing relative to the edge that accepts the word causing them. A write appears on the port in the following cycle. `err` rises in the following cycle. `list_done` pulses in the following cycle. The bench drives each word on a falling edge, lets it be taken on the next rising edge, and reads these results at the falling edge after that. The write stream is recorded at every falling edge where a handshake is pending, under three sink back-pressure patterns. That record is compared in order with address, data and select lists computed arithmetically from each command.

// File: rtl/regcmd_pkg.sv
package regcmd_pkg;
  localparam int WORD_W = 32;
  localparam int OFF_W  = 20;
  localparam int CNT_W  = 14;
  localparam int WRAP_W = 4;
  localparam int SEL_W  = 22;
  localparam int WRAP_LSB = 16;
  localparam int OP_LSB   = 27;

  localparam logic [WORD_W-1:0] SEL_MAGIC = 32'h180A_C060;

  localparam logic [3:0] OP_SINGLE = 4'b0010;
  localparam logic [3:0] OP_INDEX  = 4'b0110;
  localparam logic [3:0] OP_INCR   = 4'b1000;
  localparam logic [3:0] OP_LUT    = 4'b1010;

  localparam logic [SEL_W-1:0] VID_GRP  = 22'h00_001F;
  localparam logic [SEL_W-1:0] POST_GRP = 22'h3E_0000;

  typedef enum logic [2:0] {C_SEL, C_SINGLE, C_INDEX, C_INCR, C_LUT} cmd_e;
  typedef enum logic [1:0] {AM_FIXED, AM_LINEAR, AM_WRAP} amode_e;
  typedef enum logic [1:0] {PH_START, PH_NEED_WR, PH_ANY} phase_e;
  typedef enum logic [1:0] {S_HDR0, S_HDR1, S_PAY, S_ERR} state_e;
endpackage

// File: rtl/regcmd_word_decode.sv
module regcmd_word_decode
  import regcmd_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int WW = WRAP_W
) (
  input  logic [WORD_W-1:0] word,
  output logic              is_sel,
  output cmd_e              op,
  output logic              op_ok,
  output logic              misal,
  output logic [SEL_W-1:0]  mask,
  output logic              mask_zero,
  output logic              mask_mixed,
  output logic              wrap_bad,
  output logic [WW-1:0]     wrap,
  output logic              noinc,
  output logic [CW-1:0]     count
);
  localparam logic [SEL_W-1:0] LEGAL = VID_GRP | POST_GRP;

  logic [3:0] opf;
  assign opf = word[OP_LSB+3:OP_LSB];

  always_comb begin
    op_ok = 1'b1;
    op    = C_SINGLE;
    case (opf)
      OP_SINGLE: op = C_SINGLE;
      OP_INDEX:  op = C_INDEX;
      OP_INCR:   op = C_INCR;
      OP_LUT:    op = C_LUT;
      default:   op_ok = 1'b0;
    endcase
  end

  assign is_sel     = (word == SEL_MAGIC);
  assign misal      = |word[1:0];
  assign mask       = word[SEL_W-1:0] & LEGAL;
  assign mask_zero  = (mask == '0);
  assign mask_mixed = (|(mask & VID_GRP)) && (|(mask & POST_GRP));
  assign wrap       = word[WRAP_LSB+WW-1:WRAP_LSB];
  assign wrap_bad   = (wrap < WW'(2));
  assign noinc      = word[WORD_W-1];
  assign count      = word[CW-1:0];
endmodule

// File: rtl/regcmd_addr_gen.sv
module regcmd_addr_gen
  import regcmd_pkg::*;
#(
  parameter int AW = OFF_W,
  parameter int WW = WRAP_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  amode_e        mode,
  input  logic [WW-1:0] wrap,
  input  logic          step,
  output logic [AW-1:0] addr
);
  localparam logic [AW-1:0] STRIDE = AW'(4);

  logic [AW-1:0] base_q, cur_q;
  logic [WW-1:0] wrap_q, wcnt_q;
  amode_e        mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0; cur_q <= '0; wrap_q <= '0; wcnt_q <= '0; mode_q <= AM_FIXED;
    end else if (clr) begin
      cur_q <= '0; wcnt_q <= '0; mode_q <= AM_FIXED;
    end else if (load) begin
      base_q <= base; cur_q <= base; wrap_q <= wrap; wcnt_q <= '0; mode_q <= mode;
    end else if (step) begin
      case (mode_q)
        AM_LINEAR: cur_q <= cur_q + STRIDE;
        AM_WRAP: begin
          if (wcnt_q == wrap_q - WW'(1)) begin
            cur_q  <= base_q;
            wcnt_q <= '0;
          end else begin
            cur_q  <= cur_q + STRIDE;
            wcnt_q <= wcnt_q + WW'(1);
          end
        end
        default: cur_q <= cur_q;
      endcase
    end
  end

  assign addr = cur_q;

  // R8: the wrap position never reaches the wrap size
  p_wrap_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == AM_WRAP) |-> (wcnt_q < wrap_q));
endmodule

// File: rtl/regcmd_wr_slot.sv
module regcmd_wr_slot
  import regcmd_pkg::*;
#(
  parameter int AW = OFF_W,
  parameter int SW = SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic [AW-1:0]     ld_addr,
  input  logic [WORD_W-1:0] ld_data,
  input  logic [SW-1:0]     ld_sel,
  input  logic              wr_ready,
  output logic              wr_valid,
  output logic [AW-1:0]     wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic [SW-1:0]     wr_sel,
  output logic              free
);
  assign free = !wr_valid || wr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0; wr_addr <= '0; wr_data <= '0; wr_sel <= '0;
    end else if (clr) begin
      wr_valid <= 1'b0;
    end else if (load) begin
      wr_valid <= 1'b1;
      wr_addr  <= ld_addr;
      wr_data  <= ld_data;
      wr_sel   <= ld_sel;
    end else if (wr_ready) begin
      wr_valid <= 1'b0;
    end
  end

  // R13: a stalled write keeps its fields
  p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_sel)));
endmodule

// File: rtl/regcmd_decoder.sv
module regcmd_decoder
  import regcmd_pkg::*;
#(
  parameter int AW = OFF_W,
  parameter int CW = CNT_W,
  parameter int WW = WRAP_W,
  parameter int SW = SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [AW-1:0]     wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic [SW-1:0]     wr_sel,
  output logic              err,
  output logic              list_done
);
  localparam logic [CW-1:0] ONE = CW'(1);

  state_e          state_q;
  phase_e          phase_q;
  cmd_e            cmd_q;
  logic [AW-1:0]   off_q;
  logic [CW-1:0]   remain_q;
  logic [SW-1:0]   sel_q;
  logic            done_q;

  logic            w_is_sel, w_op_ok, w_misal, m_zero, m_mixed, w_wrap_bad, w_noinc;
  cmd_e            w_op;
  logic [SEL_W-1:0] m_val;
  logic [WW-1:0]   w_wrap;
  logic [CW-1:0]   w_count;

  regcmd_word_decode #(.CW(CW), .WW(WW)) u_dec (
    .word(in_data), .is_sel(w_is_sel), .op(w_op), .op_ok(w_op_ok), .misal(w_misal),
    .mask(m_val), .mask_zero(m_zero), .mask_mixed(m_mixed), .wrap_bad(w_wrap_bad),
    .wrap(w_wrap), .noinc(w_noinc), .count(w_count)
  );

  logic accept, slot_free, bad_h0, bad_h1, fault, eol, emit, ag_load, ag_step;
  logic [AW-1:0] ag_addr, emit_addr;
  amode_e ag_mode;

  assign in_ready = (state_q == S_ERR) || slot_free;
  assign accept   = in_valid && in_ready;

  always_comb begin
    if (w_is_sel) bad_h0 = (phase_q == PH_NEED_WR);
    else          bad_h0 = (phase_q == PH_START) || !w_op_ok || w_misal;
    case (cmd_q)
      C_SEL:   bad_h1 = (m_zero && phase_q != PH_START) || m_mixed;
      C_LUT:   bad_h1 = w_wrap_bad;
      default: bad_h1 = 1'b0;
    endcase
    case (cmd_q)
      C_INDEX: ag_mode = AM_FIXED;
      C_INCR:  ag_mode = AM_LINEAR;
      default: ag_mode = w_noinc ? AM_FIXED : AM_WRAP;
    endcase
  end

  assign fault = accept && (((state_q == S_HDR0) && bad_h0) || ((state_q == S_HDR1) && bad_h1));
  assign eol   = accept && (state_q == S_HDR1) && (cmd_q == C_SEL) && m_zero && (phase_q == PH_START);
  assign emit  = accept && !fault &&
                 (((state_q == S_HDR1) && (cmd_q == C_SINGLE)) || (state_q == S_PAY));
  assign emit_addr = (state_q == S_PAY) ? ag_addr : off_q;
  assign ag_load = accept && !fault && (state_q == S_HDR1) &&
                   (cmd_q == C_INDEX || cmd_q == C_INCR || cmd_q == C_LUT);
  assign ag_step = emit && (state_q == S_PAY);

  regcmd_addr_gen #(.AW(AW), .WW(WW)) u_ag (
    .clk(clk), .rst_n(rst_n), .clr(restart), .load(ag_load), .base(off_q),
    .mode(ag_mode), .wrap(w_wrap), .step(ag_step), .addr(ag_addr)
  );

  regcmd_wr_slot #(.AW(AW), .SW(SW)) u_slot (
    .clk(clk), .rst_n(rst_n), .clr(restart), .load(emit), .ld_addr(emit_addr),
    .ld_data(in_data), .ld_sel(sel_q), .wr_ready(wr_ready), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_sel(wr_sel), .free(slot_free)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_HDR0; phase_q <= PH_START; cmd_q <= C_SEL;
      off_q <= '0; remain_q <= '0; sel_q <= '0; done_q <= 1'b0;
    end else if (restart) begin
      state_q <= S_HDR0; phase_q <= PH_START; cmd_q <= C_SEL;
      remain_q <= '0; sel_q <= '0; done_q <= 1'b0;
    end else begin
      done_q <= eol;
      if (accept) begin
        if (fault) begin
          state_q <= S_ERR;
        end else begin
          case (state_q)
            S_HDR0: begin
              cmd_q   <= w_is_sel ? C_SEL : w_op;
              off_q   <= in_data[AW-1:0];
              if (!w_is_sel) phase_q <= PH_ANY;
              state_q <= S_HDR1;
            end
            S_HDR1: begin
              state_q <= S_HDR0;
              case (cmd_q)
                C_SEL: begin
                  if (!m_zero) begin
                    sel_q   <= m_val;
                    phase_q <= PH_NEED_WR;
                  end
                end
                C_SINGLE: ;
                default: begin
                  remain_q <= w_count;
                  if (w_count != '0) state_q <= S_PAY;
                end
              endcase
            end
            S_PAY: begin
              remain_q <= remain_q - ONE;
              if (remain_q == ONE) state_q <= S_HDR0;
            end
            default: state_q <= S_ERR;
          endcase
        end
      end
    end
  end

  assign err       = (state_q == S_ERR);
  assign list_done = done_q;

  // R11: the error flag holds until restart
  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n || restart)
    err |=> err);
  // R11: no new write starts while in error
  p_err_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n || restart)
    (err && !wr_valid) |=> !wr_valid);
  // R4: every issued write carries a legal unit mask
  p_sel_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> ((wr_sel != '0) && !((|(wr_sel & VID_GRP)) && (|(wr_sel & POST_GRP)))));
  // R2: a write header at list start is rejected
  p_first_sel_r2: assert property (@(posedge clk) disable iff (!rst_n || restart)
    (accept && state_q == S_HDR0 && phase_q == PH_START && !w_is_sel) |=> err);
  // R12: end-of-list is a single-cycle pulse
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n || restart)
    list_done |=> !list_done);
  // R13: a held write blocks the input
  p_stall_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready && !err) |-> !in_ready);
endmodule

// File: tb/regcmd_decoder_test.sv
`timescale 1ns/1ps
module regcmd_decoder_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4096;

  logic clk = 0, rst_n = 0, restart = 0, in_valid = 0, wr_ready = 1;
  logic [31:0] in_data = '0;
  logic in_ready, wr_valid, err, list_done;
  logic [19:0] wr_addr;
  logic [31:0] wr_data;
  logic [21:0] wr_sel;

  regcmd_decoder uut (
    .clk(clk), .rst_n(rst_n), .restart(restart), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_sel(wr_sel), .err(err), .list_done(list_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int bp = 0;
  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    case (bp)
      0: wr_ready <= 1'b1;
      1: wr_ready <= cyc[0];
      2: wr_ready <= (cyc % 3 == 0);
      default: wr_ready <= 1'b0;
    endcase
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic [19:0] got_a [DEPTH];
  logic [31:0] got_d [DEPTH];
  logic [21:0] got_s [DEPTH];
  logic [19:0] exp_a [DEPTH];
  logic [31:0] exp_d [DEPTH];
  logic [21:0] exp_s [DEPTH];
  int n_got = 0, n_done = 0, n_exp = 0, mark = 0, mark_done = 0;
  bit stall_q = 0;
  logic [19:0] h_a; logic [31:0] h_d; logic [21:0] h_s;

  always @(negedge clk) begin
    if (rst_n) begin
      if (stall_q)
        chk(wr_valid && wr_addr == h_a && wr_data == h_d && wr_sel == h_s,
            "R13 held write changed", {12'd0, wr_addr, wr_data}, {12'd0, h_a, h_d});
      if (wr_valid && wr_ready) begin
        got_a[n_got % DEPTH] = wr_addr;
        got_d[n_got % DEPTH] = wr_data;
        got_s[n_got % DEPTH] = wr_sel;
        n_got++;
      end
      if (list_done) n_done++;
      stall_q = wr_valid && !wr_ready;
      h_a = wr_addr; h_d = wr_data; h_s = wr_sel;
    end
  end

  task automatic send(input logic [31:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = w;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic new_case();
    @(negedge clk); restart = 1'b1;
    @(negedge clk); restart = 1'b0;
    #1; mark = n_got; mark_done = n_done; n_exp = 0;
  endtask

  task automatic expect_wr(input logic [19:0] a, input logic [31:0] d, input logic [21:0] s);
    exp_a[n_exp] = a; exp_d[n_exp] = d; exp_s[n_exp] = s; n_exp++;
  endtask

  task automatic compare(input string tag);
    repeat (10) @(negedge clk);
    #1;
    chk(n_got - mark == n_exp, {tag, " write count"}, 64'(n_got - mark), 64'(n_exp));
    for (int k = 0; k < n_exp && k < n_got - mark; k++) begin
      int g = (mark + k) % DEPTH;
      chk(got_a[g] == exp_a[k], {tag, " address"}, 64'(got_a[g]), 64'(exp_a[k]));
      chk(got_d[g] == exp_d[k], {tag, " data"}, 64'(got_d[g]), 64'(exp_d[k]));
      chk(got_s[g] == exp_s[k], {tag, " select"}, 64'(got_s[g]), 64'(exp_s[k]));
    end
  endtask

  task automatic err_after(input string tag);
    @(negedge clk);
    chk(err == 1'b1, tag, 64'(err), 64'd1);
  endtask

  function automatic logic [31:0] hdr(input logic [3:0] op, input logic [19:0] off);
    return {1'b0, op, 7'd0, off};
  endfunction

  localparam logic [31:0] MAGIC = 32'h180A_C060;
  localparam logic [19:0] OFF = 20'hFFFF8;

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(err == 0 && wr_valid == 0 && list_done == 0 && in_ready == 1, "R1 reset state",
        {60'd0, err, wr_valid, list_done, in_ready}, 64'd1);

    // sweep: modes x counts x wraps x back-pressure (R4 R5 R6 R7 R8)
    for (int b = 0; b < 3; b++) begin
      bp = b;
      for (int m = 0; m < 4; m++) begin
        for (int n = 0; n < 6; n++) begin
          for (int w = 2; w < ((m >= 2) ? 5 : 3); w++) begin
            logic [3:0] op;
            logic [31:0] w1, selw;
            logic [21:0] sel;
            string tag;
            new_case();
            case (m)
              0: begin op = 4'b1000; tag = "R6"; end
              1: begin op = 4'b0110; tag = "R7"; end
              default: begin op = 4'b1010; tag = "R8"; end
            endcase
            selw = (m < 2) ? 32'h0100_0011 : 32'h8024_0000;
            sel  = (m < 2) ? 22'h00_0011 : 22'h24_0000;
            w1 = 32'(n);
            if (m >= 2) w1 = w1 | (32'(w) << 16);
            if (m == 3) w1 = w1 | 32'h8000_0000;
            send(MAGIC); send(selw);
            send(hdr(op, OFF)); send(w1);
            for (int k = 0; k < n; k++) begin
              logic [31:0] d;
              logic [19:0] a;
              d = {8'hA5, 4'(m), 4'(n), 8'(w), 8'(k)};
              case (m)
                0: a = OFF + 20'(4 * k);
                2: a = OFF + 20'(4 * (k % w));
                default: a = OFF;
              endcase
              send(d);
              expect_wr(a, d, sel);
            end
            send(hdr(4'b0010, 20'h00100));
            send(32'h5A5A_0000 | 32'(n));
            expect_wr(20'h00100, 32'h5A5A_0000 | 32'(n), sel);
            compare(tag);
            chk(err == 0, {tag, " R5 no error"}, 64'(err), 64'd0);
          end
        end
      end
    end
    bp = 0;

    // R8 largest wrap
    new_case();
    send(MAGIC); send(32'h0002_0000);
    send(hdr(4'b1010, 20'h00200)); send((32'd15 << 16) | 32'd17);
    for (int k = 0; k < 17; k++) begin
      send(32'hC0DE_0000 + 32'(k));
      expect_wr(20'h00200 + 20'(4 * (k % 15)), 32'hC0DE_0000 + 32'(k), 22'h02_0000);
    end
    compare("R8 wrap 15");

    // R2 write first, then R11 discard, then R1 restart
    new_case();
    send(hdr(4'b0010, 20'h00010));
    err_after("R2 write before select");
    chk(in_ready == 1, "R11 in_ready in error", 64'(in_ready), 64'd1);
    send(32'h1234_5678); send(MAGIC); send(32'h11); send(hdr(4'b0010, 20'h00020)); send(32'h9);
    compare("R11 discard");
    chk(err == 1, "R11 sticky", 64'(err), 64'd1);
    new_case();
    @(negedge clk);
    chk(err == 0 && in_ready == 1 && wr_valid == 0, "R1 restart clears", {62'd0, err, in_ready}, 64'd1);

    // R3 select twice
    new_case();
    send(MAGIC); send(32'h1); send(MAGIC);
    err_after("R3 select after select");

    // R4 mixed mask, zero mask after a write
    new_case();
    send(MAGIC); send(32'h0020_0001);
    err_after("R4 mixed mask");
    new_case();
    send(MAGIC); send(32'h2); send(hdr(4'b0010, 20'h4)); send(32'h77);
    expect_wr(20'h4, 32'h77, 22'h2);
    send(MAGIC); send(32'h0);
    err_after("R4 zero mask mid list");
    compare("R4 write before zero mask");

    // R9 wrap below 2
    for (int w = 0; w < 2; w++) begin
      new_case();
      send(MAGIC); send(32'h0004_0000);
      send(hdr(4'b1010, 20'h8)); send((32'(w) << 16) | 32'd3);
      err_after("R9 wrap too small");
    end

    // R10 unknown opcode and misaligned offset
    new_case();
    send(MAGIC); send(32'h1); send(hdr(4'b0011, 20'h8));
    err_after("R10 unknown opcode");
    new_case();
    send(MAGIC); send(32'h1); send(hdr(4'b0010, 20'h6));
    err_after("R10 misaligned offset");

    // R12 end-of-list marker
    new_case();
    send(MAGIC); send(32'h0);
    @(negedge clk);
    chk(list_done == 1 && err == 0, "R12 list_done pulse", {62'd0, list_done, err}, 64'h2);
    @(negedge clk);
    chk(n_done - mark_done == 1, "R12 single pulse", 64'(n_done - mark_done), 64'd1);
    send(hdr(4'b0010, 20'h0));
    err_after("R12 select still required");

    // R13 stall and latency
    new_case();
    bp = 3;
    send(MAGIC); send(32'h8); send(hdr(4'b0010, 20'h0040)); send(32'hFEED_BEEF);
    @(negedge clk);
    chk(wr_valid == 1 && wr_addr == 20'h40 && wr_data == 32'hFEED_BEEF, "R13 write next cycle",
        {12'd0, wr_addr, wr_data}, {12'd0, 20'h40, 32'hFEED_BEEF});
    repeat (3) @(negedge clk);
    chk(in_ready == 0 && wr_valid == 1, "R13 input stalled", {62'd0, in_ready, wr_valid}, 64'd1);
    bp = 0;
    expect_wr(20'h40, 32'hFEED_BEEF, 22'h8);
    compare("R13 drained write");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule